// File: doc/BRIEF.md
# Vector Operand Index Remapper

This block sits between instruction decode and the vector register file. For each of the up to four vector operands of an instruction (three sources and one destination), it can add a per-wave register offset to the operand's register number. A mode word controls whether offsetting is on. An index word supplies the offset and a per-operand enable mask. A count says how many vector registers the wave owns.

Each operand is handled on its own. An operand whose mask bit is clear keeps its register number. An enabled operand gets the offset added. If an enabled operand is not a vector register, or its sum lands past the last owned register, the remapper does not wrap and does not raise a fault. It sends register 0 instead, and it raises a per-operand substitution flag for debug.

The result is registered once, so the remapped indices appear one clock after the inputs.

Top module: `vidx_remap`

## Requirements
- R1: While `rst_ni` is low, every output index and every substitution flag is 0.
- R2: Outputs reflect the inputs sampled at the previous rising clock edge. Between edges the outputs hold.
- R3: When bit 27 of `mode_i` is 0, every operand index passes through unchanged and every substitution flag is 0.
- R4: The offset is `index_reg_i[7:0]`. The enable mask is `index_reg_i[15:12]`: bit 12 enables operand 0 (source 0), bit 13 operand 1 (source 1), bit 14 operand 2 (source 2), and bit 15 operand 3 (destination).
- R5: An enabled operand that is a vector register and whose sum is below `vreg_count_i` is output as operand index plus offset.
- R6: An enabled vector operand whose sum, taken at 9 bits, is at least `vreg_count_i` is output as 0 with its substitution flag set.
- R7: An enabled operand whose `op_is_vec_i` bit is 0 is output as 0 with its substitution flag set.
- R8: An operand whose mask bit is clear passes through unchanged with flag 0, whatever its `op_is_vec_i` bit.
- R9: A substitution flag is 1 exactly when the operand was replaced by register 0 under R6 or R7.
- R10: All bits of `mode_i` other than bit 27, and all bits of `index_reg_i` outside 7:0 and 15:12, have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_idx_i | input | 4x8 | Register number per operand (0..2 sources, 3 destination) |
| op_is_vec_i | input | 4 | Per operand: 1 means a vector register |
| mode_i | input | 32 | Mode word; bit 27 enables offsetting |
| index_reg_i | input | 32 | Offset in 7:0, operand enable mask in 15:12 |
| vreg_count_i | input | 9 | Number of owned vector registers, 1..256 |
| op_idx_o | output | 4x8 | Remapped register number per operand |
| op_subst_o | output | 4 | Per operand: replaced by register 0 |

## Verification
The assertions assume that `vreg_count_i` lies in 1..256 and that inputs are stable around the rising edge. The out-of-range property compares the output with the count of the previous cycle and is only meaningful under these assumptions. The stimulus draws the count from 1..256 only, and it changes inputs on the falling edge. Random mode and index words fill every unused bit, so R10 is exercised throughout. Counts are skewed high so that in-range sums are common. Directed cases cover the boundary sums count-1 and count, 9-bit carry-out, and single-bit masks.

// File: rtl/vidx_pkg.sv
package vidx_pkg;
  localparam int unsigned CFG_W       = 32;
  localparam int unsigned MODE_EN_BIT = 27;
  localparam int unsigned OFS_LSB     = 0;
  localparam int unsigned MASK_LSB    = 12;
  localparam int unsigned MASK_W      = 4;
endpackage

// File: rtl/vidx_ctrl.sv
module vidx_ctrl
  import vidx_pkg::*;
#(
  parameter int unsigned NUM_OPS = 4,
  parameter int unsigned REG_W   = 8
) (
  input  logic [CFG_W-1:0]   mode_i,
  input  logic [CFG_W-1:0]   index_reg_i,
  output logic [REG_W-1:0]   offset_o,
  output logic [NUM_OPS-1:0] op_en_o
);
  logic active;
  assign active   = mode_i[MODE_EN_BIT];
  assign offset_o = index_reg_i[OFS_LSB +: REG_W];
  assign op_en_o  = active ? index_reg_i[MASK_LSB +: NUM_OPS] : '0;

  initial begin
    a_r4_mask_fits : assert (NUM_OPS <= MASK_W);
  end
endmodule

// File: rtl/vidx_lane.sv
module vidx_lane #(
  parameter int unsigned REG_W = 8,
  localparam int unsigned CNT_W = REG_W + 1
) (
  input  logic             en_i,
  input  logic             is_vec_i,
  input  logic [REG_W-1:0] idx_i,
  input  logic [REG_W-1:0] offset_i,
  input  logic [CNT_W-1:0] count_i,
  output logic [REG_W-1:0] idx_o,
  output logic             subst_o
);
  logic [CNT_W-1:0] sum;
  logic             oob;

  // widened add keeps the carry as out-of-range
  assign sum = {1'b0, idx_i} + {1'b0, offset_i};
  assign oob = (sum >= count_i);

  always_comb begin
    idx_o   = idx_i;
    subst_o = 1'b0;
    if (en_i) begin
      if (!is_vec_i || oob) begin
        idx_o   = '0;
        subst_o = 1'b1;
      end else begin
        idx_o = sum[REG_W-1:0];
      end
    end
  end
endmodule

// File: rtl/vidx_remap.sv
module vidx_remap
  import vidx_pkg::*;
#(
  parameter int unsigned NUM_OPS = 4,
  parameter int unsigned REG_W   = 8,
  localparam int unsigned CNT_W  = REG_W + 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_OPS-1:0][REG_W-1:0] op_idx_i,
  input  logic [NUM_OPS-1:0]            op_is_vec_i,
  input  logic [CFG_W-1:0]              mode_i,
  input  logic [CFG_W-1:0]              index_reg_i,
  input  logic [CNT_W-1:0]              vreg_count_i,
  output logic [NUM_OPS-1:0][REG_W-1:0] op_idx_o,
  output logic [NUM_OPS-1:0]            op_subst_o
);
  logic [REG_W-1:0]              offset;
  logic [NUM_OPS-1:0]            op_en;
  logic [NUM_OPS-1:0][REG_W-1:0] idx_d;
  logic [NUM_OPS-1:0]            subst_d;

  vidx_ctrl #(.NUM_OPS(NUM_OPS), .REG_W(REG_W)) u_ctrl (
    .mode_i      (mode_i),
    .index_reg_i (index_reg_i),
    .offset_o    (offset),
    .op_en_o     (op_en)
  );

  for (genvar k = 0; k < NUM_OPS; k++) begin : g_lane
    vidx_lane #(.REG_W(REG_W)) u_lane (
      .en_i     (op_en[k]),
      .is_vec_i (op_is_vec_i[k]),
      .idx_i    (op_idx_i[k]),
      .offset_i (offset),
      .count_i  (vreg_count_i),
      .idx_o    (idx_d[k]),
      .subst_o  (subst_d[k])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_idx_o   <= '0;
      op_subst_o <= '0;
    end else begin
      op_idx_o   <= idx_d;
      op_subst_o <= subst_d;
    end
  end

  // one clean cycle out of reset before $past is trusted
  logic primed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) primed <= 1'b0;
    else         primed <= 1'b1;
  end

  for (genvar k = 0; k < NUM_OPS; k++) begin : g_chk
    a_r9_subst_is_zero : assert property (@(posedge clk_i) disable iff (!rst_ni)
      op_subst_o[k] |-> (op_idx_o[k] == '0));
    a_r3_bypass : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (primed && $past(!mode_i[MODE_EN_BIT])) |->
        (!op_subst_o[k] && op_idx_o[k] == $past(op_idx_i[k])));
    a_r8_masked_pass : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (primed && $past(!index_reg_i[MASK_LSB+k])) |->
        (!op_subst_o[k] && op_idx_o[k] == $past(op_idx_i[k])));
    a_r7_nonvec_sub : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (primed && $past(mode_i[MODE_EN_BIT] && index_reg_i[MASK_LSB+k] && !op_is_vec_i[k]))
        |-> op_subst_o[k]);
    a_r6_in_range : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (primed && !op_subst_o[k] && $past(mode_i[MODE_EN_BIT] && index_reg_i[MASK_LSB+k]))
        |-> ({1'b0, op_idx_o[k]} < $past(vreg_count_i)));
  end

  always_comb begin
    if (!rst_ni) a_r1_reset_clear : assert (op_idx_o == '0 && op_subst_o == '0);
  end
endmodule

// File: tb/vidx_remap_bench.sv
`timescale 1ns/1ps
module vidx_remap_bench;
  localparam int NOPS = 4;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [NOPS-1:0][7:0] idx_in = '0;
  logic [NOPS-1:0]      is_vec = '0;
  logic [31:0]          mode = '0;
  logic [31:0]          ireg = '0;
  logic [8:0]           cnt = 9'd256;
  logic [NOPS-1:0][7:0] idx_out;
  logic [NOPS-1:0]      subst;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  vidx_remap u_vidx_remap (
    .clk_i(clk), .rst_ni(rst_n), .op_idx_i(idx_in), .op_is_vec_i(is_vec),
    .mode_i(mode), .index_reg_i(ireg), .vreg_count_i(cnt),
    .op_idx_o(idx_out), .op_subst_o(subst)
  );

  function automatic logic [8:0] ref_op(input int k, input logic [7:0] i,
      input logic v, input logic [31:0] m, input logic [31:0] r, input logic [8:0] c);
    int s;
    if (!m[27] || !r[12+k]) return {1'b0, i};
    s = int'(i) + int'(r[7:0]);
    if (!v || s >= int'(c)) return 9'h100;
    return {1'b0, 8'(s)};
  endfunction

  function automatic string tag_of(input int k, input logic [7:0] i,
      input logic v, input logic [31:0] m, input logic [31:0] r, input logic [8:0] c);
    if (!m[27]) return "R3";
    if (!r[12+k]) return "R8";
    if (!v) return "R7";
    if (int'(i) + int'(r[7:0]) >= int'(c)) return "R6";
    return "R5";
  endfunction

  logic [NOPS-1:0][7:0] x_idx;
  logic [NOPS-1:0]      x_sub;

  task automatic calc_exp();
    for (int k = 0; k < NOPS; k++) begin
      logic [8:0] e;
      e = ref_op(k, idx_in[k], is_vec[k], mode, ireg, cnt);
      x_sub[k] = e[8];
      x_idx[k] = e[7:0];
    end
  endtask

  task automatic check_out(input string note);
    for (int k = 0; k < NOPS; k++) begin
      n_chk++;
      if (idx_out[k] !== x_idx[k] || subst[k] !== x_sub[k]) begin
        n_bad++;
        $display("FAIL %s/R9 op%0d: got idx=%0d sub=%0b, want idx=%0d sub=%0b",
                 note, k, idx_out[k], subst[k], x_idx[k], x_sub[k]);
      end
    end
  endtask

  // drive at negedge, check at the following negedge
  task automatic apply(input string forced_tag);
    calc_exp();
    @(negedge clk);
    for (int k = 0; k < NOPS; k++) begin
      string t;
      t = (forced_tag != "") ? forced_tag :
          tag_of(k, idx_in[k], is_vec[k], mode, ireg, cnt);
      n_chk++;
      if (idx_out[k] !== x_idx[k] || subst[k] !== x_sub[k]) begin
        n_bad++;
        $display("FAIL %s/R9 op%0d: got idx=%0d sub=%0b, want idx=%0d sub=%0b",
                 t, k, idx_out[k], subst[k], x_idx[k], x_sub[k]);
      end
    end
  endtask

  task automatic set_all(input logic [31:0] m, input logic [31:0] r, input logic [8:0] c,
      input logic [31:0] idxs, input logic [3:0] v);
    mode = m; ireg = r; cnt = c; idx_in = idxs; is_vec = v;
  endtask

  initial begin
    // R1: reset state with non-zero inputs
    set_all(32'h0800_0000, 32'h0000_F005, 9'd100, 32'h0A0B0C0D, 4'hF);
    x_idx = '0; x_sub = '0;
    repeat (3) @(negedge clk);
    check_out("R1");
    rst_n = 1'b1;
    apply("");

    // R2: new inputs do not show before the edge
    calc_exp();
    set_all(32'h0800_0000, 32'h0000_F001, 9'd256, 32'h01020304, 4'hF);
    #1 check_out("R2");
    apply("R2");

    // R4: single-bit masks select one operand each
    for (int b = 0; b < 4; b++) begin
      set_all(32'h0800_0000, 32'h0000_0003 | (32'h1 << (12 + b)), 9'd200,
              32'h10203040, 4'hF);
      apply("R4");
    end
    // R6 boundaries: sum = count-1 in range, sum = count out, carry out
    set_all(32'h0800_0000, 32'h0000_F00A, 9'd64, {8'd53, 8'd54, 8'd0, 8'd255}, 4'hF);
    apply("");
    set_all(32'h0800_0000, 32'h0000_F0FF, 9'd256, {8'd0, 8'd1, 8'd128, 8'd255}, 4'hF);
    apply("");
    // R7 / R8: non-vector operands, enabled vs masked
    set_all(32'h0800_0000, 32'h0000_5002, 9'd256, 32'h05050505, 4'h0);
    apply("");
    // R3: mode bit clear, everything else set
    set_all(32'hF7FF_FFFF, 32'hFFFF_FFFF, 9'd1, 32'hFFFEFDFC, 4'h0);
    apply("R3");
    // R10: unused bits toggled with the same effective settings
    set_all(32'h0800_0000, 32'h0000_F004, 9'd128, 32'h11223344, 4'hF);
    apply("R10");
    set_all(32'hF7FF_FFFF | 32'h0800_0000, 32'hFFFF_FF04 & ~32'h0000_0F00 | 32'h0000_0F00,
            9'd128, 32'h11223344, 4'hF);
    apply("R10");

    // random mix
    void'($urandom(32'd1234));
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] m;
      logic [31:0] r;
      int c;
      m = $urandom();
      m[27] = ($urandom_range(0, 3) != 0);
      r = $urandom();
      if ($urandom_range(0, 1)) r[7:0] = 8'($urandom_range(0, 15));
      c = ($urandom_range(0, 2) != 0) ? $urandom_range(160, 256) : $urandom_range(1, 256);
      set_all(m, r, 9'(c), $urandom(), 4'($urandom()));
      if ($urandom_range(0, 1)) is_vec = 4'hF;
      apply("");
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got hang, want completion");
      end
    join_any
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule